// File: doc/BRIEF.md
# Variable-Width Logical Shift Unit

This block shifts a data word left or right by a programmed count and fills the vacated bit positions with zeros. It has two ways of working. In word mode the whole 16-bit word takes part. In field mode only a low field of 4, 8, 12 or 16 bits is shifted, and every bit above that field passes through unchanged. The count is first reduced modulo the active width, so a count larger than the width wraps around rather than clearing the result. The last bit pushed out of the word or field is kept in a carry flag.

A controller presents the operand, the count, the direction and the width selection, then asserts an execute strobe. In level mode every clock edge that sees execute high performs an operation. In pulse mode an operation happens only on the first edge after execute goes from low to high. Both the result and the carry are registered outputs.

Top module: `fshift_unit`

## Requirements
- R1: A synchronous active-low reset clears the result and the carry flag to 0.
- R2: A direction input of 0 selects a right shift. In word mode the 16-bit word moves toward bit 0 by k places, and the top k bits become 0.
- R3: A direction input of 1 selects a left shift. The word moves toward bit 15 by k places, and the bottom k bits become 0.
- R4: The count input is a 16-bit unsigned value. In word mode k = count mod 16, so a count of 18 shifts by 2.
- R5: The field-width select field_sel_i picks the active width in field mode: 00 gives 4 bits, 01 gives 8, 10 gives 12 and 11 gives 16. The shift acts only on the low bits of that width, and the result bits above the field equal the input bits. When field_mode_i is 0, the width is 16 and the select is ignored.
- R6: In field mode k = count mod (field width). This holds for the 12-bit width as well: a count of 15 on an 8-bit field shifts by 7, and a count of 13 on a 12-bit field shifts by 1.
- R7: When k is not 0, the carry receives the last bit shifted out. On a right shift that is input bit k-1. On a left shift it is input bit (width - k).
- R8: When k is 0, the operation copies the input data to the result and the carry keeps its previous value.
- R9: In level mode (pulse_mode_i = 0) the outputs update on every clock edge where exec_i is high. On an edge where exec_i is low they hold.
- R10: In pulse mode (pulse_mode_i = 1) the outputs update only on the edge where exec_i is sampled high after being low at the previous edge. While exec_i stays high they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_i | input | 1 | Execute strobe |
| pulse_mode_i | input | 1 | 1: execute on the rising edge only; 0: level execution |
| dir_left_i | input | 1 | 0: right shift, 1: left shift |
| field_mode_i | input | 1 | 1: field mode, 0: full-word mode |
| field_sel_i | input | 2 | Field width select (00=4, 01=8, 10=12, 11=16) |
| data_i | input | 16 | Operand |
| count_i | input | 16 | Unsigned shift count |
| result_o | output | 16 | Registered shifted result |
| carry_o | output | 1 | Registered carry flag (last bit shifted out) |

## Verification
The assertions assume that the inputs are stable around each rising clock edge. They also assume that exec_i is held low during reset, so that the first edge-detect comparison after reset starts from a low strobe. The bench changes every input only on the falling edge. It keeps exec_i low for the whole reset period. Its random operands, counts, widths and strobes are then all legal values, so no input lies outside the assumptions.

// File: rtl/fshift_pkg.sv
// Package: shared encodings for the variable-width shift unit.
// Assumes a data word whose width is a multiple of four.
package fshift_pkg;
    // Shift direction encoding on dir_left_i
    typedef enum logic {
        SHIFT_RIGHT = 1'b0,
        SHIFT_LEFT  = 1'b1
    } shift_dir_e;

    // Field width select encoding: width = (code + 1) * (word width / 4)
    typedef enum logic [1:0] {
        FIELD_QUARTER  = 2'b00,
        FIELD_HALF     = 2'b01,
        FIELD_3QUARTER = 2'b10,
        FIELD_FULL     = 2'b11
    } field_sel_e;

    localparam int NUM_FIELDS = 4;
endpackage

// File: rtl/fshift_modreduce.sv
// Module: fshift_modreduce
// Reduces the raw count modulo the active width and reports that width.
// Assumes DATA_W is a power of two and a multiple of NUM_FIELDS.
// Every candidate width has its own constant-divisor remainder, so the
// 3/4 width (not a power of two) gets a true modulo and not a mask.
module fshift_modreduce
    import fshift_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    localparam int SH_W  = $clog2(DATA_W),
    localparam int STEP  = DATA_W / NUM_FIELDS
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             field_mode_i,
    input  logic [1:0]       field_sel_i,
    output logic [SH_W-1:0]  shamt_o,
    output logic [SH_W:0]    width_o
);
    logic [SH_W-1:0] rem_arr [NUM_FIELDS];
    logic [1:0]      sel_idx;

    // One constant-divisor remainder per selectable width
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_rem
        localparam int GW = (g + 1) * STEP;
        assign rem_arr[g] = SH_W'(32'(count_i) % GW);
    end

    // Word mode forces the full width; field mode uses the select
    always_comb begin
        sel_idx = field_mode_i ? field_sel_i : FIELD_FULL;
        shamt_o = rem_arr[sel_idx];
        width_o = (SH_W + 1)'((32'(sel_idx) + 1) * STEP);
    end
endmodule

// File: rtl/fshift_core.sv
// Module: fshift_core
// Zero-fill logical shift confined to the low width_i bits of the word.
// Bits above the field are passed through. Also gives the last bit
// shifted out. Assumes 0 <= shamt_i < width_i <= DATA_W.
module fshift_core #(
    parameter int DATA_W = 16,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic [SH_W:0]     width_i,
    input  logic              dir_left_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    logic [DATA_W:0]   mask_wide;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] shifted;
    logic [SH_W:0]     cidx;

    // Build the field mask, shift inside it and select the carry bit
    always_comb begin
        mask_wide = ({{DATA_W{1'b0}}, 1'b1} << width_i) - 1'b1;
        mask      = mask_wide[DATA_W-1:0];
        field     = data_i & mask;
        if (dir_left_i) begin
            shifted = (field << shamt_i) & mask;
            cidx    = width_i - {1'b0, shamt_i};
        end else begin
            shifted = field >> shamt_i;
            cidx    = {1'b0, shamt_i} - 1'b1;
        end
        carry_o  = data_i[cidx[SH_W-1:0]];
        result_o = (data_i & ~mask) | shifted;
    end
endmodule

// File: rtl/fshift_trigger.sv
// Module: fshift_trigger
// Decides on which clock edges an operation is performed: on every edge
// with the strobe high (level mode), or only on the first high edge
// after a low one (pulse mode). Assumes exec_i is low during reset.
module fshift_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic exec_i,
    input  logic pulse_mode_i,
    output logic fire_o
);
    logic exec_q;

    // Remember the strobe level seen at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) exec_q <= 1'b0;
        else        exec_q <= exec_i;
    end

    // Level mode passes the strobe; pulse mode keeps only its rising edge
    always_comb begin
        fire_o = pulse_mode_i ? (exec_i & ~exec_q) : exec_i;
    end
endmodule

// File: rtl/fshift_unit.sv
// Module: fshift_unit (top)
// Registered variable-width logical shift unit with a carry flag.
// Assumes synchronous inputs that are stable around the rising edge.
module fshift_unit #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic              pulse_mode_i,
    input  logic              dir_left_i,
    input  logic              field_mode_i,
    input  logic [1:0]        field_sel_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]   shamt;
    logic [SH_W:0]     width;
    logic [DATA_W-1:0] shift_res;
    logic              shift_cy;
    logic              fire;

    fshift_modreduce #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_mod (
        .count_i      (count_i),
        .field_mode_i (field_mode_i),
        .field_sel_i  (field_sel_i),
        .shamt_o      (shamt),
        .width_o      (width)
    );

    fshift_core #(.DATA_W(DATA_W)) u_core (
        .data_i     (data_i),
        .shamt_i    (shamt),
        .width_i    (width),
        .dir_left_i (dir_left_i),
        .result_o   (shift_res),
        .carry_o    (shift_cy)
    );

    fshift_trigger u_trig (
        .clk          (clk),
        .rst_n        (rst_n),
        .exec_i       (exec_i),
        .pulse_mode_i (pulse_mode_i),
        .fire_o       (fire)
    );

    // Register the result on each operation; the carry changes only when k is not 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            carry_o  <= 1'b0;
        end else if (fire) begin
            result_o <= shift_res;
            if (shamt != '0) carry_o <= shift_cy;
        end
    end
endmodule

// File: rtl/fshift_unit_chk.sv
// Module: fshift_unit_chk
// Port-level temporal checks for fshift_unit, attached by bind.
// Assumes exec_i is low while reset is asserted.
module fshift_unit_chk #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_i,
    input logic              pulse_mode_i,
    input logic              dir_left_i,
    input logic              field_mode_i,
    input logic [1:0]        field_sel_i,
    input logic [DATA_W-1:0] data_i,
    input logic [CNT_W-1:0]  count_i,
    input logic [DATA_W-1:0] result_o,
    input logic              carry_o
);
    localparam int QW = DATA_W / 4;
    logic was_in_reset;

    // Record whether the previous edge saw reset asserted
    always_ff @(posedge clk) was_in_reset <= !rst_n;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_in_reset |-> (result_o == '0 && carry_o == 1'b0));

    assert_word_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !pulse_mode_i && !dir_left_i && !field_mode_i)
        |=> result_o == ($past(data_i) >> ($past(count_i) % DATA_W)));

    assert_upper_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !pulse_mode_i && field_mode_i && field_sel_i == 2'b00)
        |=> result_o[DATA_W-1:QW] == $past(data_i[DATA_W-1:QW]));

    assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !pulse_mode_i && !field_mode_i && (count_i % DATA_W) == 0)
        |=> (result_o == $past(data_i) && $stable(carry_o)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> ($stable(result_o) && $stable(carry_o)));

    assert_pulse_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode_i && exec_i && $past(exec_i))
        |=> ($stable(result_o) && $stable(carry_o)));
endmodule

bind fshift_unit fshift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exec_i       (exec_i),
    .pulse_mode_i (pulse_mode_i),
    .dir_left_i   (dir_left_i),
    .field_mode_i (field_mode_i),
    .field_sel_i  (field_sel_i),
    .data_i       (data_i),
    .count_i      (count_i),
    .result_o     (result_o),
    .carry_o      (carry_o)
);

// File: tb/fshift_unit_bench.sv
`timescale 1ns/1ps
// Bench for fshift_unit: directed corner cases followed by seeded random
// stimulus. Every result is compared with a bit-level reference model.
module fshift_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic        pulse_mode_i = 1'b0;
    logic        dir_left_i = 1'b0;
    logic        field_mode_i = 1'b0;
    logic [1:0]  field_sel_i = 2'b00;
    logic [15:0] data_i = '0;
    logic [15:0] count_i = '0;
    logic [15:0] result_o;
    logic        carry_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    logic [15:0] exp_res = '0;
    logic        exp_cy = 1'b0;
    logic        prev_exec = 1'b0;

    always #2.5 clk = ~clk;

    fshift_unit u_fshift_unit (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .pulse_mode_i(pulse_mode_i),
        .dir_left_i(dir_left_i), .field_mode_i(field_mode_i),
        .field_sel_i(field_sel_i), .data_i(data_i), .count_i(count_i),
        .result_o(result_o), .carry_o(carry_o)
    );

    // Reference: bit-by-bit move within the active width, returns {carry, result}
    function automatic logic [16:0] ref_shift(input logic [15:0] d, input logic [15:0] c,
                                              input logic dl, input logic fm,
                                              input logic [1:0] fs, input logic cin);
        int w = fm ? (int'(fs) + 1) * 4 : 16;
        int k = int'(c) % w;
        logic [15:0] r = d;
        logic cy = cin;
        if (k != 0) begin
            for (int i = 0; i < w; i++) begin
                int src = dl ? i - k : i + k;
                r[i] = (src >= 0 && src < w) ? d[src] : 1'b0;
            end
            cy = dl ? d[w - k] : d[k - 1];
        end
        return {cy, r};
    endfunction

    task automatic check(input string tag);
        total++;
        if (result_o !== exp_res || carry_o !== exp_cy) begin
            bad++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     tag, result_o, carry_o, exp_res, exp_cy);
        end
    endtask

    // Drive one cycle of inputs, update the model at the edge, check just after it
    task automatic step(input logic [15:0] d, input logic [15:0] c, input logic dl,
                        input logic fm, input logic [1:0] fs, input logic ex,
                        input logic pm, input string tag);
        logic [16:0] m;
        @(negedge clk);
        data_i = d; count_i = c; dir_left_i = dl; field_mode_i = fm;
        field_sel_i = fs; exec_i = ex; pulse_mode_i = pm;
        @(posedge clk);
        if (ex && (!pm || !prev_exec)) begin
            m = ref_shift(d, c, dl, fm, fs, exp_cy);
            exp_res = m[15:0];
            exp_cy = m[16];
        end
        prev_exec = ex;
        #1;
        check(tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1; check("R1 reset");
        @(negedge clk); rst_n = 1'b1;

        step(16'hAAAA, 16'd4, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, "R2 word right n=4");
        step(16'h8001, 16'd18, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, "R4 count 18 wraps to 2");
        step(16'h8001, 16'd1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, "R3 R7 left carry top bit");
        step(16'h12F0, 16'd15, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, "R6 8-bit field n=15");
        step(16'hF801, 16'd13, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, "R6 12-bit field n=13");
        step(16'hABCD, 16'd1, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, "R5 4-bit field upper pass");
        step(16'h00F0, 16'd5, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, "R5 16-bit field select");
        step(16'h0001, 16'd1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, "R7 right carry bit0");
        step(16'h1234, 16'd16, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, "R8 count 16 keeps carry");
        step(16'h5678, 16'd8, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0, "R8 field4 count 8");
        step(16'hFFFF, 16'd3, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, "R9 idle holds");
        step(16'h0F0F, 16'd2, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, "R9 level first");
        step(16'h3C3C, 16'd3, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, "R9 level repeat");
        step(16'h1111, 16'd1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, "R10 pulse low");
        step(16'h8888, 16'd2, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, "R10 pulse rise");
        step(16'h4444, 16'd1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, "R10 pulse held");

        for (int i = 0; i < 400; i++) begin
            logic pm = ($urandom_range(0, 3) == 0);
            step(16'($urandom), (i % 5 == 0) ? 16'($urandom) : 16'($urandom_range(0, 20)),
                 1'($urandom), 1'($urandom), 2'($urandom),
                 ($urandom_range(0, 3) != 0), pm, pm ? "R10 random" : "R9 random");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule